// File: doc/BRIEF.md
# Byte-Serial Host Write Port for a Character Overlay Controller

This block accepts host writes over an 8-bit parallel bus. The host qualifies the bus with an active-low select and marks each byte with the rising edge of a data strobe. The block samples the strobe, the select, the bus and an auto-clear line into its own clock domain. It then builds a write frame from successive bytes. Two bytes give an 11-bit target address. Each group of three bytes that follows gives one 18-bit data word. When a word is complete, the block decodes the address into one of three regions and raises exactly one single-cycle write strobe for that region. The strobe comes with an offset relative to the region base and with the word.

The control region is held inside the block as a small register file, and its contents are visible on a flat output bus. Display memory and glyph memory are outside the block and are driven by their strobes. After each word the address advances by one, so the host can stream consecutive words without sending the address again. A falling edge on the auto-clear line clears the register file and discards any partial frame.

Top module: `osd_host_writer`

## Requirements
- R1: After reset no write strobe is active and every control register reads zero.
- R2: Strobe rising edges that occur while the select is high are not taken as bytes, and they do not advance the frame position.
- R3: A frame starts with the address low byte. The next byte gives address bits 10:8 in its bits 2:0, and its bits 7:3 are ignored. Each data word then follows as three bytes, least significant first: bits 7:0, bits 15:8, and bits 17:16 taken from bits 1:0 of the third byte, whose bits 7:2 are ignored.
- R4: A byte is taken from the bus value present at the strobe's rising edge. A change of the bus while the strobe stays high has no effect.
- R5: Addresses 0x000 to 0x2A7 raise `disp_we`, and `wr_addr` carries the address itself.
- R6: Addresses 0x2A8 to 0x2B0 raise `ctrl_we` with `wr_addr` = address − 0x2A8. Control register k then holds the word, shown on `ctrl_q[18k+17:18k]`.
- R7: Addresses 0x300 to 0x6EC raise `glyph_we` with `wr_addr` = address − 0x300.
- R8: A word whose address lies in none of the three ranges raises no strobe and leaves every control register unchanged.
- R9: After each completed word the address increments by one, wrapping from 0x7FF to 0x000. The next three bytes form the next word.
- R10: Raising the select returns the frame to its first byte, and any partially received word is discarded.
- R11: A high-to-low transition of `host_ac_n` clears every control register. It also returns the frame to its first byte, so the next byte while selected is an address low byte.
- R12: Each completed word with a mapped address produces exactly one strobe, lasting one clock cycle. No two strobes are ever active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the host strobe |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cs_n | input | 1 | Active-low host select |
| host_sclk | input | 1 | Host data strobe; the byte is taken on its rising edge |
| host_ad | input | 8 | Host byte bus |
| host_ac_n | input | 1 | Auto-clear; a falling edge clears registers and frame state |
| disp_we | output | 1 | Display memory write strobe |
| ctrl_we | output | 1 | Control register write strobe |
| glyph_we | output | 1 | Glyph memory write strobe |
| wr_addr | output | 11 | Offset of the write inside the selected region |
| wr_data | output | 18 | Word being written |
| ctrl_q | output | 162 | Nine control registers of 18 bits, register 0 in the low bits |

## Verification
Single-word frames aimed at both ends of every range, and at the gaps between and above them, show whether the decoder boundaries and the region offsets are exact. Multi-word bursts that start just below a range edge or at 0x7FF show whether the auto-increment crosses regions and wraps correctly. Frames cut short by the select, strobe pulses sent while deselected, and an auto-clear in the middle of a frame show whether the byte position restarts where it should. Random upper bits in the second and fifth bytes, together with bus changes while the strobe is high, separate correct byte capture from capture of stray bits or late values.

// File: rtl/osd_hostif_pkg.sv
package osd_hostif_pkg;
  localparam int HBUS_W = 8;
  localparam int HADDR_W = 11;
  localparam int HDATA_W = 18;

  localparam logic [10:0] DISP_LO  = 11'h000;
  localparam logic [10:0] DISP_HI  = 11'h2A7;
  localparam logic [10:0] CTRL_LO  = 11'h2A8;
  localparam logic [10:0] CTRL_HI  = 11'h2B0;
  localparam logic [10:0] GLYPH_LO = 11'h300;
  localparam logic [10:0] GLYPH_HI = 11'h6EC;

  localparam int CTRL_N = int'(CTRL_HI) - int'(CTRL_LO) + 1;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_DISP  = 2'd1,
    RG_CTRL  = 2'd2,
    RG_GLYPH = 2'd3
  } region_e;
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
  parameter int BUS_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [BUS_W-1:0] ad,
  input  logic             ac_n,
  output logic             rst_ns,
  output logic             cs_n_s,
  output logic             sclk_rise,
  output logic [BUS_W-1:0] ad_s,
  output logic             ac_fall
);
  localparam int W = BUS_W + 3;
  localparam logic [W-1:0] IDLE = {1'b1, 1'b1, 1'b0, {BUS_W{1'b0}}};

  logic [1:0]   rs_q;
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] last_s;
  logic         sclk_d_q;
  logic         ac_d_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  // one bundle carries bus and controls so they stay aligned
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) chain_q[g] <= IDLE;
        else         chain_q[g] <= {ac_n, cs_n, sclk, ad};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) chain_q[g] <= IDLE;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign last_s = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sclk_d_q <= 1'b0;
      ac_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= last_s[BUS_W];
      ac_d_q   <= last_s[BUS_W+2];
    end
  end

  assign ad_s      = last_s[BUS_W-1:0];
  assign cs_n_s    = last_s[BUS_W+1];
  assign sclk_rise = last_s[BUS_W] & ~sclk_d_q;
  assign ac_fall   = ~last_s[BUS_W+2] & ac_d_q;
endmodule

// File: rtl/hostif_asm.sv
module hostif_asm #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 18,
  localparam int ADDR_B = (ADDR_W + BUS_W - 1) / BUS_W,
  localparam int DATA_B = (DATA_W + BUS_W - 1) / BUS_W,
  localparam int LAST   = ADDR_B + DATA_B - 1,
  localparam int CW     = $clog2(LAST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cs_n,
  input  logic              rise,
  input  logic [BUS_W-1:0]  byte_i,
  output logic              word_vld,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data,
  output logic [CW-1:0]     bcnt
);
  localparam logic [CW-1:0] ADDR_B_C = CW'(ADDR_B);
  localparam logic [CW-1:0] LAST_C   = CW'(LAST);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nxt;
  logic [DATA_W-1:0] dacc_q, dacc_d, dacc_nxt;
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  // byte lanes of the address; the top lane keeps only the bits that exist
  for (genvar k = 0; k < ADDR_B; k++) begin : g_alane
    localparam int WK = ((ADDR_W - k*BUS_W) < BUS_W) ? (ADDR_W - k*BUS_W) : BUS_W;
    assign addr_nxt[k*BUS_W +: WK] = (cnt_q == CW'(k)) ? byte_i[WK-1:0]
                                                       : addr_q[k*BUS_W +: WK];
  end

  for (genvar k = 0; k < DATA_B; k++) begin : g_dlane
    localparam int WK = ((DATA_W - k*BUS_W) < BUS_W) ? (DATA_W - k*BUS_W) : BUS_W;
    assign dacc_nxt[k*BUS_W +: WK] = (cnt_q == CW'(ADDR_B + k)) ? byte_i[WK-1:0]
                                                                : dacc_q[k*BUS_W +: WK];
  end

  always_comb begin
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    dacc_d  = dacc_q;
    vld_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (clr || cs_n) begin
      cnt_d = '0;
    end else if (rise) begin
      if (cnt_q < ADDR_B_C) begin
        addr_d = addr_nxt;
        cnt_d  = cnt_q + 1'b1;
      end else if (cnt_q == LAST_C) begin
        vld_d   = 1'b1;
        waddr_d = addr_q;
        wdata_d = dacc_nxt;
        addr_d  = addr_q + 1'b1;
        cnt_d   = ADDR_B_C;
      end else begin
        dacc_d = dacc_nxt;
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      dacc_q  <= '0;
      vld_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      dacc_q  <= dacc_d;
      vld_q   <= vld_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign word_vld  = vld_q;
  assign word_addr = waddr_q;
  assign word_data = wdata_q;
  assign bcnt      = cnt_q;
endmodule

// File: rtl/hostif_dec.sv
module hostif_dec
  import osd_hostif_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              word_vld,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] word_data,
  output logic              disp_we,
  output logic              ctrl_we,
  output logic              glyph_we,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  region_e           rg;
  logic [ADDR_W-1:0] off;
  logic              disp_d, ctrl_d, glyph_d;
  logic              disp_q, ctrl_q, glyph_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    rg  = RG_NONE;
    off = '0;
    if (word_addr <= ADDR_W'(DISP_HI)) begin
      rg  = RG_DISP;
      off = word_addr - ADDR_W'(DISP_LO);
    end else if (word_addr >= ADDR_W'(CTRL_LO) && word_addr <= ADDR_W'(CTRL_HI)) begin
      rg  = RG_CTRL;
      off = word_addr - ADDR_W'(CTRL_LO);
    end else if (word_addr >= ADDR_W'(GLYPH_LO) && word_addr <= ADDR_W'(GLYPH_HI)) begin
      rg  = RG_GLYPH;
      off = word_addr - ADDR_W'(GLYPH_LO);
    end
  end

  always_comb begin
    disp_d  = 1'b0;
    ctrl_d  = 1'b0;
    glyph_d = 1'b0;
    addr_d  = addr_q;
    data_d  = data_q;
    if (word_vld && !clr && rg != RG_NONE) begin
      disp_d  = (rg == RG_DISP);
      ctrl_d  = (rg == RG_CTRL);
      glyph_d = (rg == RG_GLYPH);
      addr_d  = off;
      data_d  = word_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q  <= 1'b0;
      ctrl_q  <= 1'b0;
      glyph_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      disp_q  <= disp_d;
      ctrl_q  <= ctrl_d;
      glyph_q <= glyph_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign disp_we  = disp_q;
  assign ctrl_we  = ctrl_q;
  assign glyph_we = glyph_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
endmodule

// File: rtl/hostif_regs.sv
module hostif_regs #(
  parameter int DATA_W = 18,
  parameter int NREG   = 9,
  localparam int IW    = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   we,
  input  logic [IW-1:0]          idx,
  input  logic [DATA_W-1:0]      wd,
  output logic [NREG*DATA_W-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] r_q, r_d;

    always_comb begin
      r_d = r_q;
      if (clr)                          r_d = '0;
      else if (we && idx == IW'(i))     r_d = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end

    assign q[i*DATA_W +: DATA_W] = r_q;
  end
endmodule

// File: rtl/osd_host_writer.sv
module osd_host_writer
  import osd_hostif_pkg::*;
#(
  parameter int BUS_W       = HBUS_W,
  parameter int ADDR_W      = HADDR_W,
  parameter int DATA_W      = HDATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_cs_n,
  input  logic                     host_sclk,
  input  logic [BUS_W-1:0]         host_ad,
  input  logic                     host_ac_n,
  output logic                     disp_we,
  output logic                     ctrl_we,
  output logic                     glyph_we,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  output logic [CTRL_N*DATA_W-1:0] ctrl_q
);
  localparam int ADDR_B = (ADDR_W + BUS_W - 1) / BUS_W;
  localparam int DATA_B = (DATA_W + BUS_W - 1) / BUS_W;
  localparam int CNT_W  = $clog2(ADDR_B + DATA_B);
  localparam int IW     = $clog2(CTRL_N);

  logic              rst_ns;
  logic              cs_n_s;
  logic              sclk_rise;
  logic [BUS_W-1:0]  ad_s;
  logic              ac_fall;
  logic              word_vld;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_data;
  logic [CNT_W-1:0]  bcnt;

  hostif_sync #(.BUS_W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .cs_n(host_cs_n), .sclk(host_sclk),
    .ad(host_ad), .ac_n(host_ac_n), .rst_ns(rst_ns), .cs_n_s(cs_n_s),
    .sclk_rise(sclk_rise), .ad_s(ad_s), .ac_fall(ac_fall)
  );

  hostif_asm #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_ns), .clr(ac_fall), .cs_n(cs_n_s), .rise(sclk_rise),
    .byte_i(ad_s), .word_vld(word_vld), .word_addr(word_addr),
    .word_data(word_data), .bcnt(bcnt)
  );

  hostif_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_ns), .clr(ac_fall), .word_vld(word_vld),
    .word_addr(word_addr), .word_data(word_data), .disp_we(disp_we),
    .ctrl_we(ctrl_we), .glyph_we(glyph_we), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  hostif_regs #(.DATA_W(DATA_W), .NREG(CTRL_N)) u_regs (
    .clk(clk), .rst_n(rst_ns), .clr(ac_fall), .we(ctrl_we),
    .idx(wr_addr[IW-1:0]), .wd(wr_data), .q(ctrl_q)
  );
endmodule

// File: rtl/osd_host_writer_chk.sv
module osd_host_writer_chk #(
  parameter int CW     = 3,
  parameter int ADDR_W = 11,
  parameter int QW     = 162
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              cs_n_s,
  input logic              ac_fall,
  input logic [CW-1:0]     bcnt,
  input logic              disp_we,
  input logic              ctrl_we,
  input logic              glyph_we,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [QW-1:0]     ctrl_q
);
  logic any_we;
  assign any_we = disp_we | ctrl_we | glyph_we;

  assert_one_region_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({disp_we, ctrl_we, glyph_we}));

  assert_strobe_pulse_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    any_we |=> !any_we);

  assert_disp_bound_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    disp_we |-> wr_addr <= ADDR_W'(11'h2A7));

  assert_ctrl_bound_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    ctrl_we |-> wr_addr <= ADDR_W'(8));

  assert_glyph_bound_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    glyph_we |-> wr_addr <= ADDR_W'(11'h3EC));

  assert_cs_restart_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    cs_n_s |=> bcnt == '0);

  assert_clear_regs_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    ac_fall |=> ctrl_q == '0);

  assert_clear_quiet_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    ac_fall |=> !any_we && bcnt == '0);
endmodule

bind osd_host_writer osd_host_writer_chk #(
  .CW(CNT_W), .ADDR_W(ADDR_W), .QW(osd_hostif_pkg::CTRL_N*DATA_W)
) u_chk (
  .clk(clk), .rst_ns(rst_ns), .cs_n_s(cs_n_s), .ac_fall(ac_fall), .bcnt(bcnt),
  .disp_we(disp_we), .ctrl_we(ctrl_we), .glyph_we(glyph_we),
  .wr_addr(wr_addr), .ctrl_q(ctrl_q)
);

// File: tb/sim_osd_host_writer.sv
`timescale 1ns/1ps
module sim_osd_host_writer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         host_cs_n, host_sclk, host_ac_n;
  logic [7:0]   host_ad;
  logic         disp_we, ctrl_we, glyph_we;
  logic [10:0]  wr_addr;
  logic [17:0]  wr_data;
  logic [161:0] ctrl_q;

  always #2.5 clk = ~clk;

  osd_host_writer u0 (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_sclk(host_sclk),
    .host_ad(host_ad), .host_ac_n(host_ac_n), .disp_we(disp_we), .ctrl_we(ctrl_we),
    .glyph_we(glyph_we), .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int          got_n = 0, exp_n = 0, cmp_i = 0;
  logic [2:0]  got_k [1024];
  logic [10:0] got_a [1024];
  logic [17:0] got_d [1024];
  logic [2:0]  exp_k [1024];
  logic [10:0] exp_a [1024];
  logic [17:0] exp_d [1024];
  logic [17:0] mreg  [9];

  // strobe monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && (disp_we | ctrl_we | glyph_we) && got_n < 1024) begin
      got_k[got_n] = ($countones({disp_we, ctrl_we, glyph_we}) > 1) ? 3'd7 :
                     disp_we ? 3'd1 : ctrl_we ? 3'd2 : 3'd3;
      got_a[got_n] = wr_addr;
      got_d[got_n] = wr_data;
      got_n++;
    end
  end

  function automatic logic [2:0] region_of(logic [10:0] a);
    if (a <= 11'h2A7) return 3'd1;
    if (a >= 11'h2A8 && a <= 11'h2B0) return 3'd2;
    if (a >= 11'h300 && a <= 11'h6EC) return 3'd3;
    return 3'd0;
  endfunction

  function automatic logic [10:0] offset_of(logic [10:0] a);
    case (region_of(a))
      3'd2:    return a - 11'h2A8;
      3'd3:    return a - 11'h300;
      default: return a;
    endcase
  endfunction

  function automatic logic [161:0] model_regs();
    logic [161:0] v;
    for (int i = 0; i < 9; i++) v[i*18 +: 18] = mreg[i];
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [191:0] act, logic [191:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b, bit wiggle);
    host_ad = b;
    tick(2);
    host_sclk = 1'b1;
    tick(3);
    if (wiggle) host_ad = ~b;
    tick(2);
    host_sclk = 1'b0;
    tick(2);
  endtask

  task automatic send_addr(logic [10:0] a);
    logic [4:0] junk;
    junk = 5'($urandom);
    send_byte(a[7:0], 1'b0);
    send_byte({junk, a[10:8]}, 1'b0);
  endtask

  task automatic send_word(logic [10:0] a, bit wiggle);
    logic [7:0]  b0, b1, b2;
    logic [17:0] w;
    logic [2:0]  k;
    b0 = 8'($urandom);
    b1 = 8'($urandom);
    b2 = 8'($urandom);
    w  = {b2[1:0], b1, b0};
    send_byte(b0, wiggle);
    send_byte(b1, wiggle);
    send_byte(b2, wiggle);
    k = region_of(a);
    if (k != 3'd0) begin
      exp_k[exp_n] = k;
      exp_a[exp_n] = offset_of(a);
      exp_d[exp_n] = w;
      exp_n++;
      if (k == 3'd2) mreg[offset_of(a)] = w;
    end
  endtask

  task automatic compare_events(string tag);
    tick(8);
    chk(got_n == exp_n, {tag, " strobe count"}, 192'(got_n), 192'(exp_n));
    while (cmp_i < exp_n && cmp_i < got_n) begin
      chk({got_k[cmp_i], got_a[cmp_i], got_d[cmp_i]} == {exp_k[cmp_i], exp_a[cmp_i], exp_d[cmp_i]},
          {tag, " region/offset/word"},
          192'({got_k[cmp_i], got_a[cmp_i], got_d[cmp_i]}),
          192'({exp_k[cmp_i], exp_a[cmp_i], exp_d[cmp_i]}));
      cmp_i++;
    end
    cmp_i = exp_n;
    got_n = exp_n;
    chk(ctrl_q == model_regs(), {tag, " control registers"}, 192'(ctrl_q), 192'(model_regs()));
  endtask

  task automatic frame(logic [10:0] a, int n, bit wiggle, string tag);
    host_cs_n = 1'b0;
    tick(2);
    send_addr(a);
    for (int i = 0; i < n; i++) send_word(a + 11'(i), wiggle);
    tick(2);
    host_cs_n = 1'b1;
    tick(4);
    compare_events(tag);
  endtask

  task automatic pulse_ac();
    host_ac_n = 1'b0;
    tick(6);
    host_ac_n = 1'b1;
    tick(6);
    for (int i = 0; i < 9; i++) mreg[i] = '0;
  endtask

  function automatic logic [10:0] pick_addr();
    case ($urandom % 6)
      0:       return 11'($urandom % 32'h2A8);
      1:       return 11'h2A8 + 11'($urandom % 9);
      2:       return 11'h300 + 11'($urandom % 32'h3ED);
      3:       return 11'h2B1 + 11'($urandom % 32'h4F);
      4:       return 11'h6ED + 11'($urandom % 32'h113);
      default: return 11'h2A5 + 11'($urandom % 16);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int i = 0; i < 9; i++) mreg[i] = '0;
    rst_n = 1'b0;
    host_cs_n = 1'b1;
    host_sclk = 1'b0;
    host_ad = '0;
    host_ac_n = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R1: quiet after reset
    chk({disp_we, ctrl_we, glyph_we} == 3'b000, "R1 strobes idle", 192'({disp_we, ctrl_we, glyph_we}), 192'(0));
    chk(ctrl_q == '0, "R1 registers zero", 192'(ctrl_q), 192'(0));

    // R5, R6, R7 boundaries; R3 via random junk bits
    frame(11'h000, 1, 1'b0, "R5 display low edge");
    frame(11'h2A7, 1, 1'b0, "R5 display high edge");
    frame(11'h2A8, 1, 1'b0, "R6 control low edge");
    frame(11'h2B0, 1, 1'b0, "R6 control high edge");
    frame(11'h300, 1, 1'b0, "R7 glyph low edge");
    frame(11'h6EC, 1, 1'b0, "R7 glyph high edge R3");
    // R8: gaps and above
    frame(11'h2B1, 1, 1'b0, "R8 gap above control");
    frame(11'h2FF, 1, 1'b0, "R8 gap below glyph");
    frame(11'h6ED, 1, 1'b0, "R8 above glyph");
    frame(11'h7FF, 1, 1'b0, "R8 top address");
    // R9: bursts crossing ranges and wrapping
    frame(11'h2A6, 4, 1'b0, "R9 burst display to control");
    frame(11'h6EB, 3, 1'b0, "R9 burst leaving glyph");
    frame(11'h7FF, 2, 1'b0, "R9 wrap to zero");
    frame(11'h2AE, 4, 1'b0, "R9 burst through control R12");
    // R4: bus changes while strobe high
    frame(11'h2AC, 2, 1'b1, "R4 late bus change");

    // R2: pulses while deselected are not bytes
    host_cs_n = 1'b1;
    for (int i = 0; i < 4; i++) send_byte(8'($urandom), 1'b0);
    compare_events("R2 deselected pulses");
    frame(11'h2A9, 1, 1'b0, "R2 frame after deselected pulses");

    // R10: abort after partial word
    host_cs_n = 1'b0;
    tick(2);
    send_addr(11'h2AA);
    send_byte(8'h5A, 1'b0);
    send_byte(8'hA5, 1'b0);
    host_cs_n = 1'b1;
    tick(4);
    compare_events("R10 partial word dropped");
    frame(11'h2AB, 1, 1'b0, "R10 fresh frame after abort");

    // R11: clear registers
    pulse_ac();
    compare_events("R11 auto-clear zeroes registers");
    frame(11'h2A8, 3, 1'b0, "R11 refill");
    // R11: clear mid-frame, select still low
    host_cs_n = 1'b0;
    tick(2);
    send_addr(11'h2AD);
    send_byte(8'h33, 1'b0);
    pulse_ac();
    send_addr(11'h2AF);
    send_word(11'h2AF, 1'b0);
    tick(2);
    host_cs_n = 1'b1;
    tick(4);
    compare_events("R11 frame restarts after clear");

    // random frames
    for (int f = 0; f < 50; f++) begin
      frame(pick_addr(), 1 + int'($urandom % 3), bit'($urandom % 2), "R3 R5 R6 R7 R8 R9 random frame");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule